// File: doc/BRIEF.md
# Trace Cache Lookup and Hit Logic

This block is a direct-mapped store of dynamic instruction traces placed beside the core fetch path. Each line records a trace as it actually ran: up to sixteen instructions covering up to three basic blocks. The line also holds the taken/not-taken outcome of each branch inside the trace. A trace is therefore identified by two things together: its starting address and the directions of its inner branches.

Every cycle the block receives a fetch address and a vector of branch predictions. If the indexed line is valid, its tag matches and its stored branch directions agree with the predictions, the whole trace is placed in the output latch on the next clock edge. The block also supplies the address to fetch next. If any of those conditions fails, a 2:1 selector passes the core fetch path's instruction block, count and next address into the same latch.

A separate fill unit delivers completed lines through a write port.

Top module: `trace_fetch_cache`

## Requirements
- R1: A synchronous active-high reset clears every line's valid bit and clears the output latch: `hit`, `out_count`, `out_next_addr` and `out_instrs` all read zero in the cycle after the reset edge. Lookups after reset miss until a line is filled again.
- R2: The fetch address is split so that bits [2:0] select one of eight lines and bits [15:3] form the tag. A hit requires the selected line to be valid and its stored tag to equal the tag bits of the fetch address.
- R3: Each line stores a branch count (0 to 3) and three direction flags, where bit i refers to the i-th branch of the trace and 1 means taken. A hit requires `pred[i]` to equal flag i for every i below the branch count. Prediction bits at or above the branch count are ignored.
- R4: Outputs are registered. On a hit, the cycle after the lookup shows `hit`=1 and the stored trace on `out_instrs`, with instruction slot k at bits [32k+31:32k]. `out_count` shows the stored instruction count.
- R5: On a hit, `out_next_addr` is the stored target address when the line has at least one branch and the prediction for its last branch (`pred[count-1]`) is taken. Otherwise it is the stored fall-through address.
- R6: On a miss, the cycle after the lookup shows `hit`=0 together with the `core_instrs`, `core_count` and `core_next_addr` values that were present at the lookup.
- R7: A fill write replaces the line selected by bits [2:0] of `fill_addr` and sets its valid bit. The new line is seen by lookups from the next cycle on. A lookup in the same cycle as the write sees the previous contents.
- R8: Two start addresses that share index bits but differ in tag bits cannot both be resident. Only the most recently filled one hits; a lookup of the other misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| fetch_addr | input | 16 | Fetch address for this cycle's lookup |
| pred | input | 3 | Branch predictions, bit i for the i-th branch |
| core_instrs | input | 512 | Instruction block from the core fetch path |
| core_count | input | 5 | Number of valid instructions on the core path |
| core_next_addr | input | 16 | Next fetch address proposed by the core path |
| fill_we | input | 1 | Fill write strobe |
| fill_addr | input | 16 | Start address of the trace being written |
| fill_flags | input | 3 | Branch direction flags of the trace |
| fill_br_count | input | 2 | Number of branches in the trace (0 to 3) |
| fill_len | input | 5 | Number of instructions in the trace |
| fill_fall_addr | input | 16 | Fall-through address at the end of the trace |
| fill_targ_addr | input | 16 | Target address of the trace's last branch |
| fill_instrs | input | 512 | Trace instructions, slot k at bits [32k+31:32k] |
| hit | output | 1 | Latched trace hit indication |
| out_instrs | output | 512 | Latched instruction block sent to decode |
| out_count | output | 5 | Latched count of valid instructions |
| out_next_addr | output | 16 | Latched next fetch address |

## Verification
Assertions check three things on every cycle. Reset must leave no valid line and no hit. A fill must set the valid bit of its line, and valid bits must not change without a write or reset. A miss must hand the core path's values through the latch unchanged.

Only the bench's scenarios can show the hit decision and its outputs. These include masking of predictions beyond the branch count and the choice between target and fall-through. The bench also covers aliasing between tags on one index and the ordering of a lookup against a same-cycle fill. It compares each of these against a reference model of the line store.

// File: rtl/tc_pkg.sv
package tc_pkg;
    parameter int ADDR_W  = 16;
    parameter int INSTR_W = 32;
    parameter int N_INSTR = 16;
    parameter int M_BLK   = 3;
    parameter int LINES   = 8;

    localparam int IDX_W   = $clog2(LINES);
    localparam int TAG_W   = ADDR_W - IDX_W;
    localparam int CNT_W   = $clog2(N_INSTR + 1);
    localparam int BRC_W   = $clog2(M_BLK + 1);
    localparam int TRACE_W = N_INSTR * INSTR_W;

    typedef struct packed {
        logic [TAG_W-1:0]   tag;
        logic [M_BLK-1:0]   flags;
        logic [BRC_W-1:0]   br_count;
        logic [CNT_W-1:0]   len;
        logic [ADDR_W-1:0]  fall_addr;
        logic [ADDR_W-1:0]  targ_addr;
        logic [TRACE_W-1:0] instrs;
    } line_t;

    typedef struct packed {
        logic               hit;
        logic [TRACE_W-1:0] instrs;
        logic [CNT_W-1:0]   count;
        logic [ADDR_W-1:0]  next_addr;
    } latch_t;
endpackage

// File: rtl/tc_line_store.sv
module tc_line_store
    import tc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  line_t            wr_line,
    input  logic [IDX_W-1:0] rd_idx,
    output line_t            rd_line,
    output logic             rd_valid
);
    typedef struct packed {
        logic [LINES-1:0]  valid;
        line_t [LINES-1:0] lines;
    } store_t;

    store_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rst) begin
            st_d.valid = '0;
        end else if (wr_en) begin
            st_d.valid[wr_idx] = 1'b1;
            st_d.lines[wr_idx] = wr_line;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    // Lookup sees the contents held before any write on this edge
    assign rd_line  = st_q.lines[rd_idx];
    assign rd_valid = st_q.valid[rd_idx];

    assert_reset_clears_valid_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (st_q.valid == '0));

    assert_fill_sets_valid_R7: assert property (@(posedge clk) disable iff (rst)
        ($past(wr_en) && !$past(rst)) |-> st_q.valid[$past(wr_idx)]);

    assert_valid_stable_without_write_R7: assert property (@(posedge clk) disable iff (rst)
        (!$past(wr_en) && !$past(rst)) |-> $stable(st_q.valid));
endmodule

// File: rtl/tc_hit_logic.sv
module tc_hit_logic
    import tc_pkg::*;
(
    input  logic              line_valid,
    input  line_t             line,
    input  logic [TAG_W-1:0]  fetch_tag,
    input  logic [M_BLK-1:0]  pred,
    output logic              hit,
    output logic [ADDR_W-1:0] next_addr
);
    logic [M_BLK-1:0] slot_ok;
    logic [M_BLK-1:0] slot_last_taken;

    // Per branch slot: agree with the stored flag, or lie past the branch count
    for (genvar i = 0; i < M_BLK; i++) begin : g_slot
        assign slot_ok[i] = (BRC_W'(i) >= line.br_count) || (pred[i] == line.flags[i]);
        assign slot_last_taken[i] = (BRC_W'(i + 1) == line.br_count) && pred[i];
    end

    assign hit       = line_valid && (line.tag == fetch_tag) && (&slot_ok);
    assign next_addr = (|slot_last_taken) ? line.targ_addr : line.fall_addr;
endmodule

// File: rtl/tc_out_latch.sv
module tc_out_latch
    import tc_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               sel_trace,
    input  logic [TRACE_W-1:0] trace_instrs,
    input  logic [CNT_W-1:0]   trace_count,
    input  logic [ADDR_W-1:0]  trace_next,
    input  logic [TRACE_W-1:0] core_instrs,
    input  logic [CNT_W-1:0]   core_count,
    input  logic [ADDR_W-1:0]  core_next,
    output latch_t             latch_q
);
    latch_t latch_d;

    always_comb begin
        latch_d = latch_q;
        if (rst) begin
            latch_d = '0;
        end else if (sel_trace) begin
            latch_d.hit       = 1'b1;
            latch_d.instrs    = trace_instrs;
            latch_d.count     = trace_count;
            latch_d.next_addr = trace_next;
        end else begin
            latch_d.hit       = 1'b0;
            latch_d.instrs    = core_instrs;
            latch_d.count     = core_count;
            latch_d.next_addr = core_next;
        end
    end

    always_ff @(posedge clk) begin
        latch_q <= latch_d;
    end

    assert_miss_passes_core_R6: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !latch_q.hit) |->
            (latch_q.instrs == $past(core_instrs) && latch_q.count == $past(core_count)
             && latch_q.next_addr == $past(core_next)));
endmodule

// File: rtl/trace_fetch_cache.sv
module trace_fetch_cache
    import tc_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [ADDR_W-1:0]  fetch_addr,
    input  logic [M_BLK-1:0]   pred,
    input  logic [TRACE_W-1:0] core_instrs,
    input  logic [CNT_W-1:0]   core_count,
    input  logic [ADDR_W-1:0]  core_next_addr,
    input  logic               fill_we,
    input  logic [ADDR_W-1:0]  fill_addr,
    input  logic [M_BLK-1:0]   fill_flags,
    input  logic [BRC_W-1:0]   fill_br_count,
    input  logic [CNT_W-1:0]   fill_len,
    input  logic [ADDR_W-1:0]  fill_fall_addr,
    input  logic [ADDR_W-1:0]  fill_targ_addr,
    input  logic [TRACE_W-1:0] fill_instrs,
    output logic               hit,
    output logic [TRACE_W-1:0] out_instrs,
    output logic [CNT_W-1:0]   out_count,
    output logic [ADDR_W-1:0]  out_next_addr
);
    line_t             wr_line;
    line_t             rd_line;
    logic              rd_valid;
    logic              lookup_hit;
    logic [ADDR_W-1:0] lookup_next;
    latch_t            latch_q;

    always_comb begin
        wr_line           = '0;
        wr_line.tag       = fill_addr[ADDR_W-1:IDX_W];
        wr_line.flags     = fill_flags;
        wr_line.br_count  = fill_br_count;
        wr_line.len       = fill_len;
        wr_line.fall_addr = fill_fall_addr;
        wr_line.targ_addr = fill_targ_addr;
        wr_line.instrs    = fill_instrs;
    end

    tc_line_store u_store (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (fill_we),
        .wr_idx   (fill_addr[IDX_W-1:0]),
        .wr_line  (wr_line),
        .rd_idx   (fetch_addr[IDX_W-1:0]),
        .rd_line  (rd_line),
        .rd_valid (rd_valid)
    );

    tc_hit_logic u_hit (
        .line_valid (rd_valid),
        .line       (rd_line),
        .fetch_tag  (fetch_addr[ADDR_W-1:IDX_W]),
        .pred       (pred),
        .hit        (lookup_hit),
        .next_addr  (lookup_next)
    );

    tc_out_latch u_latch (
        .clk          (clk),
        .rst          (rst),
        .sel_trace    (lookup_hit),
        .trace_instrs (rd_line.instrs),
        .trace_count  (rd_line.len),
        .trace_next   (lookup_next),
        .core_instrs  (core_instrs),
        .core_count   (core_count),
        .core_next    (core_next_addr),
        .latch_q      (latch_q)
    );

    assign hit           = latch_q.hit;
    assign out_instrs    = latch_q.instrs;
    assign out_count     = latch_q.count;
    assign out_next_addr = latch_q.next_addr;

    assert_no_hit_after_reset_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !hit);
endmodule

// File: tb/trace_fetch_cache_bench.sv
`timescale 1ns/1ps
module trace_fetch_cache_bench;
    import tc_pkg::*;

    logic               clk = 1'b0;
    logic               rst;
    logic [ADDR_W-1:0]  fetch_addr;
    logic [M_BLK-1:0]   pred;
    logic [TRACE_W-1:0] core_instrs;
    logic [CNT_W-1:0]   core_count;
    logic [ADDR_W-1:0]  core_next_addr;
    logic               fill_we;
    logic [ADDR_W-1:0]  fill_addr;
    logic [M_BLK-1:0]   fill_flags;
    logic [BRC_W-1:0]   fill_br_count;
    logic [CNT_W-1:0]   fill_len;
    logic [ADDR_W-1:0]  fill_fall_addr;
    logic [ADDR_W-1:0]  fill_targ_addr;
    logic [TRACE_W-1:0] fill_instrs;
    logic               hit;
    logic [TRACE_W-1:0] out_instrs;
    logic [CNT_W-1:0]   out_count;
    logic [ADDR_W-1:0]  out_next_addr;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic              m_valid [LINES];
    logic [ADDR_W-1:0] m_start [LINES];
    logic [M_BLK-1:0]  m_flags [LINES];
    int                m_brc   [LINES];
    logic [CNT_W-1:0]  m_len   [LINES];
    logic [ADDR_W-1:0] m_fall  [LINES];
    logic [ADDR_W-1:0] m_targ  [LINES];
    logic [TRACE_W-1:0] m_ins  [LINES];
    logic [ADDR_W-1:0] starts [$];

    always #2 clk = ~clk;

    trace_fetch_cache u_trace_fetch_cache (.*);

    function automatic logic [TRACE_W-1:0] rand_block();
        logic [TRACE_W-1:0] t;
        for (int k = 0; k < N_INSTR; k++) t[k*INSTR_W +: INSTR_W] = $urandom;
        return t;
    endfunction

    function automatic bit model_hit(logic [ADDR_W-1:0] a, logic [M_BLK-1:0] p);
        int ix = int'(a[IDX_W-1:0]);
        if (!m_valid[ix] || m_start[ix][ADDR_W-1:IDX_W] != a[ADDR_W-1:IDX_W]) return 0;
        for (int i = 0; i < m_brc[ix]; i++)
            if (p[i] != m_flags[ix][i]) return 0;
        return 1;
    endfunction

    function automatic logic [ADDR_W-1:0] model_next(logic [ADDR_W-1:0] a, logic [M_BLK-1:0] p);
        int ix = int'(a[IDX_W-1:0]);
        if (m_brc[ix] == 0) return m_fall[ix];
        return p[m_brc[ix]-1] ? m_targ[ix] : m_fall[ix];
    endfunction

    task automatic check(string req, string what, logic [TRACE_W-1:0] act, logic [TRACE_W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // One clock: expectation from the model before this edge, then model update, then compare
    task automatic step(string req);
        logic               e_hit;
        logic [TRACE_W-1:0] e_ins;
        logic [CNT_W-1:0]   e_cnt;
        logic [ADDR_W-1:0]  e_nxt;
        if (rst) begin
            e_hit = 0; e_ins = '0; e_cnt = '0; e_nxt = '0;
        end else if (model_hit(fetch_addr, pred)) begin
            e_hit = 1;
            e_ins = m_ins[int'(fetch_addr[IDX_W-1:0])];
            e_cnt = m_len[int'(fetch_addr[IDX_W-1:0])];
            e_nxt = model_next(fetch_addr, pred);
        end else begin
            e_hit = 0; e_ins = core_instrs; e_cnt = core_count; e_nxt = core_next_addr;
        end
        @(posedge clk);
        if (rst) begin
            for (int i = 0; i < LINES; i++) m_valid[i] = 0;
        end else if (fill_we) begin
            int ix = int'(fill_addr[IDX_W-1:0]);
            m_valid[ix] = 1; m_start[ix] = fill_addr; m_flags[ix] = fill_flags;
            m_brc[ix] = int'(fill_br_count); m_len[ix] = fill_len;
            m_fall[ix] = fill_fall_addr; m_targ[ix] = fill_targ_addr; m_ins[ix] = fill_instrs;
        end
        #1;
        check(req, "hit", TRACE_W'(hit), TRACE_W'(e_hit));
        check(req, "instrs", out_instrs, e_ins);
        check(req, "count", TRACE_W'(out_count), TRACE_W'(e_cnt));
        check(req, "next", TRACE_W'(out_next_addr), TRACE_W'(e_nxt));
        @(negedge clk);
    endtask

    task automatic set_fill(logic [ADDR_W-1:0] a, logic [M_BLK-1:0] f, int brc);
        fill_we = 1; fill_addr = a; fill_flags = f; fill_br_count = BRC_W'(brc);
        fill_len = CNT_W'($urandom_range(1, N_INSTR));
        fill_fall_addr = ADDR_W'($urandom); fill_targ_addr = ADDR_W'($urandom);
        fill_instrs = rand_block();
    endtask

    task automatic set_core();
        core_instrs = rand_block();
        core_count = CNT_W'($urandom_range(0, N_INSTR));
        core_next_addr = ADDR_W'($urandom);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        #400000;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'd2024));
        for (int i = 0; i < LINES; i++) begin m_valid[i] = 0; m_brc[i] = 0; end
        rst = 1; fill_we = 0; fill_addr = '0; fill_flags = '0; fill_br_count = '0;
        fill_len = '0; fill_fall_addr = '0; fill_targ_addr = '0; fill_instrs = '0;
        fetch_addr = '0; pred = '0;
        set_core();
        @(negedge clk);
        step("R1");
        step("R1");
        rst = 0;
        set_core(); fetch_addr = 16'h1235;
        step("R1");  // empty store misses, core path passes

        // R3/R5: no branches, any prediction hits, fall-through chosen
        set_fill(16'h0040, 3'b000, 0); step("R7");
        fill_we = 0; fetch_addr = 16'h0040; pred = 3'b111; set_core(); step("R3");
        // R3: two branches, flags taken on branch 1 only; pred[2] ignored; last taken -> target
        set_fill(16'h0A21, 3'b010, 2); step("R7");
        fill_we = 0; fetch_addr = 16'h0A21; pred = 3'b110; step("R5");
        pred = 3'b010; step("R3");
        pred = 3'b011; step("R3");  // branch 0 mismatches: miss
        // R5: three branches, last not taken -> fall-through
        set_fill(16'h0033, 3'b011, 3); step("R7");
        fill_we = 0; fetch_addr = 16'h0033; pred = 3'b011; step("R5");
        pred = 3'b111; step("R5");  // last branch differs: miss
        // R2/R8: alias tag on the same index misses, refill replaces
        fetch_addr = 16'h1A21; pred = 3'b010; step("R8");
        set_fill(16'h1A21, 3'b001, 1); step("R8");
        fill_we = 0; fetch_addr = 16'h0A21; pred = 3'b010; step("R8");
        fetch_addr = 16'h1A21; pred = 3'b001; step("R2");
        // R7: lookup during a write to its own line sees old contents, new next cycle
        set_fill(16'h2A21, 3'b000, 0); fetch_addr = 16'h1A21; step("R7");
        fill_we = 0; step("R7");
        fetch_addr = 16'h2A21; step("R7");

        for (int i = 0; i < LINES; i++) starts.push_back(m_start[i]);
        for (int n = 0; n < 3000; n++) begin
            set_core();
            if ($urandom_range(0, 3) == 0) begin
                logic [ADDR_W-1:0] a;
                a = ($urandom_range(0, 1) == 0) ? ADDR_W'($urandom_range(0, 63)) : ADDR_W'($urandom);
                set_fill(a, M_BLK'($urandom), $urandom_range(0, M_BLK));
                starts.push_back(a);
            end else fill_we = 0;
            if ($urandom_range(0, 9) < 7)
                fetch_addr = starts[$urandom_range(0, starts.size() - 1)];
            else
                fetch_addr = ADDR_W'($urandom);
            pred = M_BLK'($urandom);
            step("R4");
        end

        // R1: reset drops every line
        fill_we = 0; rst = 1; step("R1");
        rst = 0; fetch_addr = 16'h2A21; pred = 3'b000; set_core(); step("R1");
        finish_run();
    end
endmodule